// File: doc/BRIEF.md
# ALU Result Flag Generator

This block derives the status flags of an arithmetic or logic result and keeps the processor's control flags. An ALU outside the block computes the raw result and its carry. The block takes both operands, that result, the adder's carry out and a two-bit operation class. A width select chooses between byte mode (8 bits) and word mode (16 bits). From these the block produces zero, sign, carry, overflow and parity. The five result flags are captured only when the update strobe is high.

The block also holds three control bits: interrupt enable, string direction and single-step trace. These change only through their own write port, which carries a per-bit mask. When trace is on, each instruction-completion pulse from the sequencer produces a one-cycle trap request. When interrupt enable is off, maskable interrupt requests are blocked at the block's output.

Top module: `alu_flag_unit`

## Requirements
- R1: The zero flag is 1 exactly when the result at the selected width is all zeros. Byte mode (wide=0) looks only at bits 7..0; word mode (wide=1) looks at bits 15..0.
- R2: The sign flag equals the top bit of the result at the selected width: bit 7 in byte mode, bit 15 in word mode.
- R3: For op_class 0 (add), the carry flag equals carry_in_raw, the adder's carry out of the top bit at the selected width. For op_class 1 (subtract), the ALU forms a + ~b + 1, and the carry flag is the borrow, the inverse of carry_in_raw.
- R4: The overflow flag is 1 when the signed add or subtract result is outside the signed range of the selected width: -128..127 for bytes, -32768..32767 for words.
- R5: The parity flag is 1 when bits 7..0 of the result hold an even number of ones. This holds in both byte and word mode, and upper bits are never counted.
- R6: For op_class 2 (logical) and the unused code 3, the carry and overflow flags are cleared, whatever carry_in_raw is.
- R7: The five result flags reset to 0. They load only on a clock edge where upd_en is 1, and they appear one cycle after that edge. Without upd_en they hold.
- R8: The control bits reset to 0. When ctl_wr_en is 1, each bit whose ctl_mask bit is set takes the matching ctl_data bit, and masked-off bits hold. Bit 0 is interrupt enable, bit 1 is direction and bit 2 is trace. dir_down is 1 for descending string addresses and 0 for ascending.
- R9: trap_req is high for exactly the one cycle after an edge where instr_done is 1 and trace is set. Otherwise it is 0.
- R10: irq_take is high in the cycle after an edge where irq_in is 1 and interrupt enable is set. While interrupt enable is 0, requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_en | input | 1 | Capture strobe for the result flags |
| op_class | input | 2 | 0 add, 1 subtract, 2 or 3 logical |
| wide | input | 1 | 1 word mode, 0 byte mode |
| opnd_a | input | 16 | First operand |
| opnd_b | input | 16 | Second operand (the subtrahend for subtract) |
| alu_res | input | 16 | Raw ALU result |
| carry_in_raw | input | 1 | Adder carry out of the selected top bit |
| ctl_wr_en | input | 1 | Control bit write strobe |
| ctl_mask | input | 3 | Per-bit write enable for the control bits |
| ctl_data | input | 3 | New control bit values |
| instr_done | input | 1 | Instruction completion pulse |
| irq_in | input | 1 | Maskable interrupt request |
| zf | output | 1 | Zero flag |
| sf | output | 1 | Sign flag |
| cf | output | 1 | Carry or borrow flag |
| of | output | 1 | Overflow flag |
| pf | output | 1 | Parity flag |
| ie_flag | output | 1 | Interrupt enable bit |
| dir_down | output | 1 | Direction bit |
| trace_on | output | 1 | Trace bit |
| trap_req | output | 1 | Single-step trap pulse |
| irq_take | output | 1 | Gated interrupt request |

## Verification
Every output is a register, so each result is due exactly one clock edge after the stimulus that causes it. The result flags follow the edge that sees upd_en. The control bits follow the edge that sees ctl_wr_en. trap_req and irq_take follow the edge that sees instr_done or irq_in. The bench drives inputs on the falling edge, lets one rising edge pass, and samples on the next falling edge. For the pulse and hold cases it samples one further cycle to confirm that the output has dropped or stayed put. The expected values come from integer arithmetic in the bench: signed range tests for overflow, unsigned compares for borrow, and bit counting for parity.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;
  typedef enum logic [1:0] {
    OPC_ADD   = 2'd0,
    OPC_SUB   = 2'd1,
    OPC_LOGIC = 2'd2,
    OPC_RSVD  = 2'd3
  } op_class_e;

  localparam int CTL_BITS = 3;
  localparam int CTL_IE   = 0;
  localparam int CTL_DIR  = 1;
  localparam int CTL_TRC  = 2;

  typedef struct packed {
    logic z;
    logic s;
    logic c;
    logic o;
    logic p;
  } arith_flags_t;
endpackage

// File: rtl/parity_tree.sv
module parity_tree #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] data,
  output logic             even
);
  localparam int NODES = 2 * WIDTH - 1;
  logic [NODES-1:0] node;

  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_leaf
      assign node[WIDTH-1+gi] = data[gi];
    end
    for (gi = 0; gi < WIDTH - 1; gi++) begin : g_inner
      assign node[gi] = node[2*gi+1] ^ node[2*gi+2];
    end
  endgenerate

  assign even = ~node[0];
endmodule

// File: rtl/flag_calc.sv
module flag_calc
  import alu_flag_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  parameter int PAR_W  = 8
) (
  input  logic [1:0]        op_class,
  input  logic              wide,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [DATA_W-1:0] alu_res,
  input  logic              carry_in_raw,
  output arith_flags_t      nxt
);
  localparam int WMSB = DATA_W - 1;
  localparam int BMSB = BYTE_W - 1;

  op_class_e opc;
  logic      a_top, b_top, r_top;
  logic      zero_byte, zero_word, par_even;
  logic      is_add, is_sub;

  assign opc = op_class_e'(op_class);

  parity_tree #(.WIDTH(PAR_W)) u_par (
    .data (alu_res[PAR_W-1:0]),
    .even (par_even)
  );

  always_comb begin
    zero_byte = (alu_res[BMSB:0] == '0);
    zero_word = (alu_res == '0);
    a_top     = wide ? opnd_a[WMSB]  : opnd_a[BMSB];
    b_top     = wide ? opnd_b[WMSB]  : opnd_b[BMSB];
    r_top     = wide ? alu_res[WMSB] : alu_res[BMSB];
    is_add    = (opc == OPC_ADD);
    is_sub    = (opc == OPC_SUB);

    nxt.z = wide ? zero_word : zero_byte;
    nxt.s = r_top;
    nxt.p = par_even;
    nxt.c = 1'b0;
    nxt.o = 1'b0;
    if (is_add) begin
      nxt.c = carry_in_raw;
      nxt.o = (a_top == b_top) && (r_top != a_top);
    end else if (is_sub) begin
      nxt.c = ~carry_in_raw;
      nxt.o = (a_top != b_top) && (r_top != a_top);
    end
  end
endmodule

// File: rtl/ctl_flag_reg.sv
module ctl_flag_reg
  import alu_flag_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                ctl_wr_en,
  input  logic [CTL_BITS-1:0] ctl_mask,
  input  logic [CTL_BITS-1:0] ctl_data,
  input  logic                instr_done,
  input  logic                irq_in,
  output logic [CTL_BITS-1:0] ctl_q,
  output logic                trap_req,
  output logic                irq_take
);
  genvar gi;
  generate
    for (gi = 0; gi < CTL_BITS; gi++) begin : g_bit
      always_ff @(posedge clk) begin
        if (rst) begin
          ctl_q[gi] <= 1'b0;
        end else if (ctl_wr_en && ctl_mask[gi]) begin
          ctl_q[gi] <= ctl_data[gi];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_req <= 1'b0;
      irq_take <= 1'b0;
    end else begin
      trap_req <= instr_done & ctl_q[CTL_TRC];
      irq_take <= irq_in & ctl_q[CTL_IE];
    end
  end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import alu_flag_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  parameter int PAR_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_en,
  input  logic [1:0]        op_class,
  input  logic              wide,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [DATA_W-1:0] alu_res,
  input  logic              carry_in_raw,
  input  logic              ctl_wr_en,
  input  logic [2:0]        ctl_mask,
  input  logic [2:0]        ctl_data,
  input  logic              instr_done,
  input  logic              irq_in,
  output logic              zf,
  output logic              sf,
  output logic              cf,
  output logic              of,
  output logic              pf,
  output logic              ie_flag,
  output logic              dir_down,
  output logic              trace_on,
  output logic              trap_req,
  output logic              irq_take
);
  arith_flags_t        nxt_flags;
  arith_flags_t        flags_q;
  logic [CTL_BITS-1:0] ctl_q;

  flag_calc #(
    .DATA_W (DATA_W),
    .BYTE_W (BYTE_W),
    .PAR_W  (PAR_W)
  ) u_calc (
    .op_class     (op_class),
    .wide         (wide),
    .opnd_a       (opnd_a),
    .opnd_b       (opnd_b),
    .alu_res      (alu_res),
    .carry_in_raw (carry_in_raw),
    .nxt          (nxt_flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
    end else if (upd_en) begin
      flags_q <= nxt_flags;
    end
  end

  ctl_flag_reg u_ctl (
    .clk        (clk),
    .rst        (rst),
    .ctl_wr_en  (ctl_wr_en),
    .ctl_mask   (ctl_mask),
    .ctl_data   (ctl_data),
    .instr_done (instr_done),
    .irq_in     (irq_in),
    .ctl_q      (ctl_q),
    .trap_req   (trap_req),
    .irq_take   (irq_take)
  );

  assign zf       = flags_q.z;
  assign sf       = flags_q.s;
  assign cf       = flags_q.c;
  assign of       = flags_q.o;
  assign pf       = flags_q.p;
  assign ie_flag  = ctl_q[CTL_IE];
  assign dir_down = ctl_q[CTL_DIR];
  assign trace_on = ctl_q[CTL_TRC];
endmodule

// File: rtl/alu_flag_chk.sv
module alu_flag_chk #(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              upd_en,
  input logic [1:0]        op_class,
  input logic              wide,
  input logic [DATA_W-1:0] alu_res,
  input logic              ctl_wr_en,
  input logic              instr_done,
  input logic              irq_in,
  input logic              zf,
  input logic              sf,
  input logic              cf,
  input logic              of,
  input logic              pf,
  input logic              ie_flag,
  input logic              dir_down,
  input logic              trace_on,
  input logic              trap_req,
  input logic              irq_take
);
  assert_zero_R1: assert property (@(posedge clk) disable iff (rst)
    upd_en |=> zf == ($past(wide) ? ($past(alu_res) == '0)
                                  : ($past(alu_res[BYTE_W-1:0]) == '0)));

  assert_parity_R5: assert property (@(posedge clk) disable iff (rst)
    upd_en |=> pf == ~(^$past(alu_res[7:0])));

  assert_logic_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (upd_en && op_class[1]) |=> (!cf && !of));

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !upd_en |=> $stable({zf, sf, cf, of, pf}));

  assert_ctl_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !ctl_wr_en |=> $stable({ie_flag, dir_down, trace_on}));

  assert_trap_R9: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> ($past(instr_done) && $past(trace_on)));

  assert_irq_R10: assert property (@(posedge clk) disable iff (rst)
    irq_take |-> ($past(irq_in) && $past(ie_flag)));
endmodule

bind alu_flag_unit alu_flag_chk #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .upd_en     (upd_en),
  .op_class   (op_class),
  .wide       (wide),
  .alu_res    (alu_res),
  .ctl_wr_en  (ctl_wr_en),
  .instr_done (instr_done),
  .irq_in     (irq_in),
  .zf         (zf),
  .sf         (sf),
  .cf         (cf),
  .of         (of),
  .pf         (pf),
  .ie_flag    (ie_flag),
  .dir_down   (dir_down),
  .trace_on   (trace_on),
  .trap_req   (trap_req),
  .irq_take   (irq_take)
);

// File: tb/alu_flag_unit_tb.sv
module alu_flag_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        upd_en = 1'b0;
  logic [1:0]  op_class = 2'd0;
  logic        wide = 1'b0;
  logic [15:0] opnd_a = '0, opnd_b = '0, alu_res = '0;
  logic        carry_in_raw = 1'b0;
  logic        ctl_wr_en = 1'b0;
  logic [2:0]  ctl_mask = '0, ctl_data = '0;
  logic        instr_done = 1'b0, irq_in = 1'b0;
  logic        zf, sf, cf, of, pf, ie_flag, dir_down, trace_on, trap_req, irq_take;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_flag_unit u_dut (
    .clk(clk), .rst(rst), .upd_en(upd_en), .op_class(op_class), .wide(wide),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .alu_res(alu_res), .carry_in_raw(carry_in_raw),
    .ctl_wr_en(ctl_wr_en), .ctl_mask(ctl_mask), .ctl_data(ctl_data),
    .instr_done(instr_done), .irq_in(irq_in),
    .zf(zf), .sf(sf), .cf(cf), .of(of), .pf(pf),
    .ie_flag(ie_flag), .dir_down(dir_down), .trace_on(trace_on),
    .trap_req(trap_req), .irq_take(irq_take)
  );

  task automatic chk(input string req, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0b expected %0b", req, got, exp);
    end
  endtask

  // Drive one result with strobe; expected flags from integer arithmetic.
  task automatic arith(input logic [1:0] op, input logic w,
                       input logic [15:0] a, input logic [15:0] b,
                       input logic force_carry);
    int width, sa, sb, sr, smin, smax, ones;
    int unsigned ua, ub, mask;
    logic [16:0] sum;
    logic [15:0] r;
    logic cr, e_c, e_o, e_z, e_s, e_p;
    width = w ? 16 : 8;
    mask  = (1 << width) - 1;
    ua = a & mask; ub = b & mask;
    sa = (ua >= (1 << (width-1))) ? int'(ua) - (1 << width) : int'(ua);
    sb = (ub >= (1 << (width-1))) ? int'(ub) - (1 << width) : int'(ub);
    smax = (1 << (width-1)) - 1; smin = -(1 << (width-1));
    e_c = 1'b0; e_o = 1'b0;
    if (op == 2'd0) begin
      sum = {1'b0, a} + {1'b0, b};
      r = sum[15:0];
      cr = ((ua + ub) >> width) & 1;
      e_c = cr;
      sr = sa + sb; e_o = (sr > smax) || (sr < smin);
    end else if (op == 2'd1) begin
      r = a - b;
      cr = ((ua + ((~ub) & mask) + 1) >> width) & 1;
      e_c = (ua < ub);
      sr = sa - sb; e_o = (sr > smax) || (sr < smin);
    end else begin
      r = a & b;
      cr = force_carry;
    end
    e_z = ((r & mask) == 0);
    e_s = w ? r[15] : r[7];
    ones = 0;
    for (int i = 0; i < 8; i++) ones += r[i];
    e_p = (ones % 2) == 0;
    @(negedge clk);
    op_class = op; wide = w; opnd_a = a; opnd_b = b; alu_res = r;
    carry_in_raw = cr; upd_en = 1'b1;
    @(negedge clk);
    upd_en = 1'b0;
    chk("R1 zero", zf, e_z);
    chk("R2 sign", sf, e_s);
    if (op[1]) begin
      chk("R6 carry clear", cf, 1'b0);
      chk("R6 overflow clear", of, 1'b0);
    end else begin
      chk("R3 carry", cf, e_c);
      chk("R4 overflow", of, e_o);
    end
    chk("R5 parity", pf, e_p);
  endtask

  task automatic t_reset;
    chk("R7 reset zf", zf, 1'b0);
    chk("R7 reset cf", cf, 1'b0);
    chk("R7 reset pf", pf, 1'b0);
    chk("R8 reset ie", ie_flag, 1'b0);
    chk("R8 reset dir", dir_down, 1'b0);
    chk("R8 reset trace", trace_on, 1'b0);
    chk("R9 reset trap", trap_req, 1'b0);
  endtask

  task automatic t_byte_add;
    arith(2'd0, 1'b0, 16'h007F, 16'h0001, 1'b0);
    chk("R4 byte signed overflow", of, 1'b1);
    arith(2'd0, 1'b0, 16'h12FF, 16'h0001, 1'b0);
    chk("R1 byte zero with upper bits set", zf, 1'b1);
    chk("R3 byte carry out", cf, 1'b1);
  endtask

  task automatic t_word_add;
    arith(2'd0, 1'b1, 16'h7FFF, 16'h0001, 1'b0);
    chk("R4 word overflow", of, 1'b1);
    arith(2'd0, 1'b1, 16'hFFFF, 16'h0001, 1'b0);
    arith(2'd0, 1'b1, 16'h1234, 16'h4321, 1'b0);
  endtask

  task automatic t_sub;
    arith(2'd1, 1'b0, 16'h0005, 16'h0006, 1'b0);
    chk("R3 byte borrow", cf, 1'b1);
    arith(2'd1, 1'b1, 16'h8000, 16'h0001, 1'b0);
    chk("R4 word sub overflow", of, 1'b1);
    arith(2'd1, 1'b1, 16'h0009, 16'h0009, 1'b0);
    chk("R3 no borrow on equal", cf, 1'b0);
  endtask

  task automatic t_logic;
    arith(2'd2, 1'b1, 16'hF0F0, 16'hFFFF, 1'b1);
    arith(2'd3, 1'b0, 16'h00FF, 16'h0080, 1'b1);
  endtask

  task automatic t_parity_word;
    arith(2'd0, 1'b1, 16'h0003, 16'h0100, 1'b0);
    chk("R5 word parity low byte even", pf, 1'b1);
    arith(2'd0, 1'b1, 16'h0007, 16'h0100, 1'b0);
    chk("R5 word parity low byte odd", pf, 1'b0);
  endtask

  task automatic t_hold;
    logic z0, c0, p0;
    arith(2'd0, 1'b0, 16'h00FF, 16'h0001, 1'b0);
    z0 = zf; c0 = cf; p0 = pf;
    @(negedge clk);
    op_class = 2'd0; wide = 1'b1; opnd_a = 16'h4000; opnd_b = 16'h4000;
    alu_res = 16'h8000; carry_in_raw = 1'b1; upd_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R7 hold zf", zf, z0);
    chk("R7 hold cf", cf, c0);
    chk("R7 hold pf", pf, p0);
    chk("R7 hold of", of, 1'b0);
  endtask

  task automatic t_ctl;
    @(negedge clk);
    ctl_wr_en = 1'b1; ctl_mask = 3'b001; ctl_data = 3'b111;
    @(negedge clk);
    ctl_wr_en = 1'b0;
    chk("R8 ie written", ie_flag, 1'b1);
    chk("R8 dir masked", dir_down, 1'b0);
    chk("R8 trace masked", trace_on, 1'b0);
    ctl_wr_en = 1'b1; ctl_mask = 3'b110; ctl_data = 3'b010;
    @(negedge clk);
    ctl_wr_en = 1'b0; ctl_mask = 3'b111; ctl_data = 3'b000;
    chk("R8 dir descending", dir_down, 1'b1);
    chk("R8 ie kept", ie_flag, 1'b1);
    @(negedge clk);
    chk("R8 no write without strobe", dir_down, 1'b1);
  endtask

  task automatic t_trap;
    @(negedge clk);
    instr_done = 1'b1;
    @(negedge clk);
    instr_done = 1'b0;
    chk("R9 no trap when trace off", trap_req, 1'b0);
    ctl_wr_en = 1'b1; ctl_mask = 3'b100; ctl_data = 3'b100;
    @(negedge clk);
    ctl_wr_en = 1'b0;
    instr_done = 1'b1;
    @(negedge clk);
    instr_done = 1'b0;
    chk("R9 trap pulse", trap_req, 1'b1);
    @(negedge clk);
    chk("R9 trap one cycle", trap_req, 1'b0);
  endtask

  task automatic t_irq;
    @(negedge clk);
    ctl_wr_en = 1'b1; ctl_mask = 3'b001; ctl_data = 3'b000;
    @(negedge clk);
    ctl_wr_en = 1'b0; irq_in = 1'b1;
    @(negedge clk);
    chk("R10 irq ignored", irq_take, 1'b0);
    irq_in = 1'b0; ctl_wr_en = 1'b1; ctl_data = 3'b001;
    @(negedge clk);
    ctl_wr_en = 1'b0; irq_in = 1'b1;
    @(negedge clk);
    irq_in = 1'b0;
    chk("R10 irq passed", irq_take, 1'b1);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_byte_add();
    t_word_add();
    t_sub();
    t_logic();
    t_parity_word();
    t_hold();
    t_ctl();
    t_trap();
    t_irq();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule